// File: doc/BRIEF.md
# Banked Scratchpad Datapath with Lane Crossbars and Result Collector

This block is the storage and steering path of a multi-bank scratchpad that serves a vector of lanes. Each cycle an upstream stage hands it one conflict-free sub-request. The sub-request is either a load or a store. Each lane carries an enable bit, a bank number, an offset inside that bank, a data word and per-byte write enables. An input crossbar routes every enabled lane to the bank it names. Each bank is a single-port array with per-byte write enables. An output crossbar returns the word read from a bank to every lane that asked for it, so several lanes that name the same bank and offset all receive the same word.

A vector access that hits a bank more than once is split upstream into several sub-requests on consecutive cycles. The last sub-request is flagged. A collector of one register per lane gathers the read results as they arrive. Two clock edges after the flagged sub-request is accepted, the collector presents the whole vector together with a one-cycle valid pulse. A lane that is not served in a sub-request keeps its value.

Top module: `lane_bank_datapath`

## Requirements
- R1: During and right after reset, `resp_valid` is 0 and every lane of `resp_data` is 0.
- R2: When `req_valid`=1 and `req_write`=1, each enabled lane writes into bank `lane_bank[l]` at word `lane_off[l]` only the bytes whose `lane_be[l]` bit is 1; bit i covers data bits 8i+7..8i. The other bytes of that word keep their contents.
- R3: A lane with `lane_en`=0 writes nothing, and its collector register does not change.
- R4: When `req_valid`=1 and `req_write`=0, each enabled lane receives the word at its bank and offset. Lanes that name distinct banks are all served in the same sub-request. Lanes that name the same bank and offset all receive that word.
- R5: Results from the sub-requests of one vector build up in the collector. A lane served in an earlier sub-request keeps its word through later sub-requests that do not serve it.
- R6: `resp_valid` is 1 exactly in the cycle after the second rising edge following a clock edge where `req_valid`=1 and `req_last`=1, and is 0 otherwise.
- R7: While `req_valid`=0, no bank is written and `resp_data` does not change, whatever the other inputs hold.
- R8: A store sub-request leaves `resp_data` unchanged. It still produces the `resp_valid` pulse when it is flagged last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| req_valid | input | 1 | A sub-request is present this cycle |
| req_last | input | 1 | This sub-request completes the vector |
| req_write | input | 1 | 1 = store, 0 = load, shared by all lanes |
| lane_en | input | LANES | Per-lane enable, becomes the bank enable |
| lane_bank | input | LANES x BANK_W | Target bank per lane |
| lane_off | input | LANES x OFF_W | Word offset inside the bank per lane |
| lane_wdata | input | LANES x WORD_W | Store data per lane |
| lane_be | input | LANES x WORD_W/8 | Byte write enables per lane |
| resp_valid | output | 1 | One-cycle pulse marking the collected vector |
| resp_data | output | LANES x WORD_W | Collected per-lane load results |

## Verification
Two functions can act in the same cycle. The collector can be taking the read data of one sub-request while the crossbar steers the next one, which may be a store or a load from another bank. Back-to-back sub-requests provoke this: a serialized three-part vector, and random traffic that mixes loads, stores, broadcasts and masked lanes on every cycle. Each cycle a behavioural model with its own memory and a two-stage pipeline predicts `resp_valid` and every lane of `resp_data`, and the design is judged against it on every clock.

// File: rtl/lbd_pkg.sv
package lbd_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic {
    OP_LOAD  = 1'b0,
    OP_STORE = 1'b1
  } op_e;
endpackage

// File: rtl/lbd_in_xbar.sv
module lbd_in_xbar #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned BANKS  = 8,
  parameter int unsigned BANK_W = 3,
  parameter int unsigned OFF_W  = 4,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned NBYTES = 4
) (
  input  logic                              req_valid,
  input  logic [LANES-1:0]                  lane_en,
  input  logic [LANES-1:0][BANK_W-1:0]      lane_bank,
  input  logic [LANES-1:0][OFF_W-1:0]       lane_off,
  input  logic [LANES-1:0][WORD_W-1:0]      lane_wdata,
  input  logic [LANES-1:0][NBYTES-1:0]      lane_be,
  output logic [BANKS-1:0]                  bank_act,
  output logic [BANKS-1:0][OFF_W-1:0]       bank_off,
  output logic [BANKS-1:0][WORD_W-1:0]      bank_wdata,
  output logic [BANKS-1:0][NBYTES-1:0]      bank_be
);
  // Per bank: the lowest-numbered enabled lane naming it drives the port.
  // Upstream guarantees all such lanes share one offset.
  always_comb begin
    for (int b = 0; b < BANKS; b++) begin
      bank_act[b]   = 1'b0;
      bank_off[b]   = '0;
      bank_wdata[b] = '0;
      bank_be[b]    = '0;
      for (int l = LANES - 1; l >= 0; l--) begin
        if (req_valid && lane_en[l] && (lane_bank[l] == BANK_W'(b))) begin
          bank_act[b]   = 1'b1;
          bank_off[b]   = lane_off[l];
          bank_wdata[b] = lane_wdata[l];
          bank_be[b]    = lane_be[l];
        end
      end
    end
  end
endmodule

// File: rtl/lbd_bank.sv
module lbd_bank
  import lbd_pkg::*;
#(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned OFF_W  = 4,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned NBYTES = 4
) (
  input  logic              clk,
  input  logic              act,
  input  logic              we,
  input  logic [OFF_W-1:0]  off,
  input  logic [WORD_W-1:0] wdata,
  input  logic [NBYTES-1:0] be,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [WORD_W-1:0] rdata_q;

  // Single port: one access per cycle, either a byte-masked write or a read.
  always_ff @(posedge clk) begin
    if (act && we) begin
      for (int i = 0; i < NBYTES; i++) begin
        if (be[i]) mem[off][i*BYTE_W +: BYTE_W] <= wdata[i*BYTE_W +: BYTE_W];
      end
    end
    if (act && !we) rdata_q <= mem[off];
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/lbd_out_xbar.sv
module lbd_out_xbar #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned BANKS  = 8,
  parameter int unsigned BANK_W = 3,
  parameter int unsigned WORD_W = 32
) (
  input  logic [BANKS-1:0][WORD_W-1:0] bank_rdata,
  input  logic [LANES-1:0][BANK_W-1:0] lane_sel_q,
  output logic [LANES-1:0][WORD_W-1:0] lane_rdata
);
  // Each lane picks the bank it addressed last cycle; equal selects broadcast.
  always_comb begin
    for (int l = 0; l < LANES; l++) lane_rdata[l] = bank_rdata[lane_sel_q[l]];
  end
endmodule

// File: rtl/lbd_collector.sv
module lbd_collector #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned WORD_W = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [LANES-1:0]             rd_pend_q,
  input  logic                         last_q,
  input  logic [LANES-1:0][WORD_W-1:0] lane_rdata,
  output logic                         resp_valid,
  output logic [LANES-1:0][WORD_W-1:0] resp_data
);
  logic [LANES-1:0][WORD_W-1:0] col_q, col_d;
  logic                         vld_q, vld_d;

  always_comb begin
    vld_d = last_q;
    col_d = col_q;
    for (int l = 0; l < LANES; l++) begin
      if (rd_pend_q[l]) col_d[l] = lane_rdata[l];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (|rd_pend_q) col_q <= col_d;
    end
  end

  assign resp_valid = vld_q;
  assign resp_data  = col_q;
endmodule

// File: rtl/lane_bank_datapath.sv
module lane_bank_datapath
  import lbd_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned BANKS  = 8,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned BANK_W = $clog2(BANKS),
  localparam int unsigned OFF_W  = $clog2(DEPTH),
  localparam int unsigned NBYTES = WORD_W / BYTE_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic                         req_last,
  input  logic                         req_write,
  input  logic [LANES-1:0]             lane_en,
  input  logic [LANES-1:0][BANK_W-1:0] lane_bank,
  input  logic [LANES-1:0][OFF_W-1:0]  lane_off,
  input  logic [LANES-1:0][WORD_W-1:0] lane_wdata,
  input  logic [LANES-1:0][NBYTES-1:0] lane_be,
  output logic                         resp_valid,
  output logic [LANES-1:0][WORD_W-1:0] resp_data
);
  op_e                          op;
  logic [BANKS-1:0]             bank_act;
  logic [BANKS-1:0][OFF_W-1:0]  bank_off;
  logic [BANKS-1:0][WORD_W-1:0] bank_wdata;
  logic [BANKS-1:0][NBYTES-1:0] bank_be;
  logic [BANKS-1:0][WORD_W-1:0] bank_rdata;
  logic [LANES-1:0][WORD_W-1:0] lane_rdata;

  logic [LANES-1:0]             rd_pend_d, rd_pend_q;
  logic [LANES-1:0][BANK_W-1:0] sel_d, sel_q;
  logic                         sel_en;
  logic                         last_d, last_q;

  assign op = op_e'(req_write);

  lbd_in_xbar #(
    .LANES(LANES), .BANKS(BANKS), .BANK_W(BANK_W),
    .OFF_W(OFF_W), .WORD_W(WORD_W), .NBYTES(NBYTES)
  ) u_in_xbar (
    .req_valid (req_valid),
    .lane_en   (lane_en),
    .lane_bank (lane_bank),
    .lane_off  (lane_off),
    .lane_wdata(lane_wdata),
    .lane_be   (lane_be),
    .bank_act  (bank_act),
    .bank_off  (bank_off),
    .bank_wdata(bank_wdata),
    .bank_be   (bank_be)
  );

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    lbd_bank #(
      .DEPTH(DEPTH), .OFF_W(OFF_W), .WORD_W(WORD_W), .NBYTES(NBYTES)
    ) u_bank (
      .clk  (clk),
      .act  (bank_act[b]),
      .we   (op == OP_STORE),
      .off  (bank_off[b]),
      .wdata(bank_wdata[b]),
      .be   (bank_be[b]),
      .rdata(bank_rdata[b])
    );
  end

  // Stage between bank read and collector: who read, from where, and last flag.
  always_comb begin
    rd_pend_d = (req_valid && op == OP_LOAD) ? lane_en : '0;
    sel_en    = req_valid && op == OP_LOAD;
    sel_d     = lane_bank;
    last_d    = req_valid && req_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend_q <= '0;
      sel_q     <= '0;
      last_q    <= 1'b0;
    end else begin
      rd_pend_q <= rd_pend_d;
      last_q    <= last_d;
      if (sel_en) sel_q <= sel_d;
    end
  end

  lbd_out_xbar #(
    .LANES(LANES), .BANKS(BANKS), .BANK_W(BANK_W), .WORD_W(WORD_W)
  ) u_out_xbar (
    .bank_rdata(bank_rdata),
    .lane_sel_q(sel_q),
    .lane_rdata(lane_rdata)
  );

  lbd_collector #(
    .LANES(LANES), .WORD_W(WORD_W)
  ) u_collector (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_pend_q (rd_pend_q),
    .last_q    (last_q),
    .lane_rdata(lane_rdata),
    .resp_valid(resp_valid),
    .resp_data (resp_data)
  );
endmodule

// File: rtl/lbd_checker.sv
module lbd_checker #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned WORD_W = 32
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         req_valid,
  input logic                         req_last,
  input logic                         req_write,
  input logic [LANES-1:0]             lane_en,
  input logic                         resp_valid,
  input logic [LANES-1:0][WORD_W-1:0] resp_data
);
  logic             fin1_q, fin2_q;
  logic             any_ld_q, st_q;
  logic [LANES-1:0] ld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fin1_q   <= 1'b0;
      fin2_q   <= 1'b0;
      any_ld_q <= 1'b0;
      st_q     <= 1'b0;
      ld_q     <= '0;
    end else begin
      fin1_q   <= req_valid && req_last;
      fin2_q   <= fin1_q;
      any_ld_q <= req_valid && !req_write && (|lane_en);
      st_q     <= req_valid && req_write;
      ld_q     <= (req_valid && !req_write) ? lane_en : '0;
    end
  end

  AST_RESP_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid == fin2_q); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !any_ld_q |=> $stable(resp_data)); // R7

  AST_STORE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    st_q |=> $stable(resp_data)); // R8

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    AST_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_q[l] |=> $stable(resp_data[l])); // R3
  end
endmodule

bind lane_bank_datapath lbd_checker #(
  .LANES(LANES), .WORD_W(WORD_W)
) u_lbd_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_last  (req_last),
  .req_write (req_write),
  .lane_en   (lane_en),
  .resp_valid(resp_valid),
  .resp_data (resp_data)
);

// File: tb/sim_lane_bank_datapath.sv
module sim_lane_bank_datapath;
  localparam int CLK_PERIOD = 10;
  localparam int LANES  = 4;
  localparam int BANKS  = 8;
  localparam int DEPTH  = 16;
  localparam int WORD_W = 32;
  localparam int BANK_W = $clog2(BANKS);
  localparam int OFF_W  = $clog2(DEPTH);
  localparam int NBYTES = WORD_W / 8;

  logic clk, rst_n, req_valid, req_last, req_write;
  logic [LANES-1:0]             lane_en;
  logic [LANES-1:0][BANK_W-1:0] lane_bank;
  logic [LANES-1:0][OFF_W-1:0]  lane_off;
  logic [LANES-1:0][WORD_W-1:0] lane_wdata;
  logic [LANES-1:0][NBYTES-1:0] lane_be;
  logic                         resp_valid;
  logic [LANES-1:0][WORD_W-1:0] resp_data;

  lane_bank_datapath #(.LANES(LANES), .BANKS(BANKS), .DEPTH(DEPTH), .WORD_W(WORD_W)) u0 (.*);

  int checks = 0, errors = 0, cyc = 0;
  string cur_tag = "R1";

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] fdat(int b, int o);
    return {8'hC3, 8'(b), 8'(o), 8'h5A};
  endfunction

  // Behavioural reference: own memory, one read stage, collector.
  logic [31:0] mmem [BANKS][DEPTH];
  logic [31:0] m_rd  [LANES];
  logic [31:0] e_col [LANES];
  bit          m_pend [LANES];
  bit          m_last, e_valid, m_live;

  initial m_live = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_last = 0; e_valid = 0; m_live = 1'b1;
      for (int l = 0; l < LANES; l++) begin m_pend[l] = 0; e_col[l] = '0; end
    end else begin
      e_valid = m_last;
      for (int l = 0; l < LANES; l++) if (m_pend[l]) e_col[l] = m_rd[l];
      m_last = req_valid && req_last;
      for (int l = 0; l < LANES; l++) begin
        m_pend[l] = req_valid && !req_write && lane_en[l];
        if (m_pend[l]) m_rd[l] = mmem[lane_bank[l]][lane_off[l]];
      end
      if (req_valid && req_write)
        for (int l = LANES - 1; l >= 0; l--)
          if (lane_en[l])
            for (int i = 0; i < NBYTES; i++)
              if (lane_be[l][i]) mmem[lane_bank[l]][lane_off[l]][i*8 +: 8] = lane_wdata[l][i*8 +: 8];
    end
  end

  always @(negedge clk) begin
    if (rst_n && m_live) begin
      chk(resp_valid == e_valid, "R6", 32'(resp_valid), 32'(e_valid));
      for (int l = 0; l < LANES; l++)
        chk(resp_data[l] == e_col[l], cur_tag, resp_data[l], e_col[l]);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic idle();
    req_valid = 0; req_last = 0; req_write = 0; lane_en = '0;
    @(negedge clk);
  endtask

  task automatic lane_set(int l, int b, int o, logic [31:0] d, logic [3:0] be);
    lane_bank[l] = BANK_W'(b); lane_off[l] = OFF_W'(o); lane_wdata[l] = d; lane_be[l] = be;
  endtask

  task automatic issue(bit wr, bit last, logic [LANES-1:0] en);
    req_valid = 1; req_write = wr; req_last = last; lane_en = en;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_last = 0; req_write = 0;
    lane_en = '0; lane_bank = '0; lane_off = '0; lane_wdata = '0; lane_be = '0;
    repeat (3) @(negedge clk);
    chk(resp_valid == 1'b0, "R1", 32'(resp_valid), 0);
    rst_n = 1;
    @(negedge clk);
    for (int l = 0; l < LANES; l++) chk(resp_data[l] == '0, "R1", resp_data[l], 0);

    // Fill every word; stores flagged last must pulse but not touch the collector (R8).
    cur_tag = "R8";
    for (int o = 0; o < DEPTH; o++)
      for (int g = 0; g < BANKS / LANES; g++) begin
        for (int l = 0; l < LANES; l++) lane_set(l, g*LANES + l, o, fdat(g*LANES + l, o), 4'hF);
        issue(1, 1, '1);
      end
    idle();

    // R4: distinct banks in one sub-request.
    cur_tag = "R4";
    lane_set(0, 3, 2, 0, 0); lane_set(1, 0, 7, 0, 0); lane_set(2, 6, 7, 0, 0); lane_set(3, 5, 15, 0, 0);
    issue(0, 1, '1); idle();
    chk(resp_valid == 1'b1, "R6", 32'(resp_valid), 1);
    chk(resp_data[0] == fdat(3, 2), "R4", resp_data[0], fdat(3, 2));
    chk(resp_data[3] == fdat(5, 15), "R4", resp_data[3], fdat(5, 15));

    // R4: broadcast of one word to all lanes.
    for (int l = 0; l < LANES; l++) lane_set(l, 4, 9, 0, 0);
    issue(0, 1, '1); idle();
    for (int l = 0; l < LANES; l++) chk(resp_data[l] == fdat(4, 9), "R4", resp_data[l], fdat(4, 9));

    // R2: partial store with bytes 0 and 2 enabled, then read back.
    cur_tag = "R2";
    lane_set(0, 2, 3, 32'h11223344, 4'b0101);
    issue(1, 1, 4'b0001);
    issue(0, 1, 4'b0001); idle();
    chk(resp_data[0] == {8'hC3, 8'h22, 8'h03, 8'h44}, "R2", resp_data[0], {8'hC3, 8'h22, 8'h03, 8'h44});

    // R3: masked lanes keep the broadcast value; masked store writes nothing.
    cur_tag = "R3";
    lane_set(0, 1, 0, 0, 0); lane_set(1, 1, 4, 0, 0); lane_set(2, 7, 1, 0, 0); lane_set(3, 1, 8, 0, 0);
    issue(0, 1, 4'b0101); idle();
    chk(resp_data[1] == fdat(4, 9), "R3", resp_data[1], fdat(4, 9));
    chk(resp_data[3] == fdat(4, 9), "R3", resp_data[3], fdat(4, 9));
    chk(resp_data[2] == fdat(7, 1), "R3", resp_data[2], fdat(7, 1));
    lane_set(0, 5, 5, 32'hDEAD0001, 4'hF); lane_set(1, 6, 6, 32'hBADBAD00, 4'hF);
    issue(1, 1, 4'b0001);
    issue(0, 1, 4'b0010); idle();
    chk(resp_data[1] == fdat(6, 6), "R3", resp_data[1], fdat(6, 6));

    // R5: one vector in three serialized sub-requests.
    cur_tag = "R5";
    lane_set(0, 0, 1, 0, 0); issue(0, 0, 4'b0001);
    lane_set(1, 2, 4, 0, 0); lane_set(2, 3, 4, 0, 0); issue(0, 0, 4'b0110);
    lane_set(3, 7, 8, 0, 0); issue(0, 1, 4'b1000);
    idle();
    chk(resp_valid == 1'b1, "R5", 32'(resp_valid), 1);
    chk(resp_data[0] == fdat(0, 1), "R5", resp_data[0], fdat(0, 1));
    chk(resp_data[1] == fdat(2, 4), "R5", resp_data[1], fdat(2, 4));
    chk(resp_data[2] == fdat(3, 4), "R5", resp_data[2], fdat(3, 4));
    chk(resp_data[3] == fdat(7, 8), "R5", resp_data[3], fdat(7, 8));

    // R7: inputs busy but req_valid low.
    cur_tag = "R7";
    for (int l = 0; l < LANES; l++) lane_set(l, l, 0, 32'hFFFF0000, 4'hF);
    req_valid = 0; req_write = 1; req_last = 1; lane_en = '1;
    repeat (3) @(negedge clk);
    req_write = 0;
    repeat (2) @(negedge clk);
    chk(resp_data[3] == fdat(7, 8), "R7", resp_data[3], fdat(7, 8));
    lane_set(0, 0, 0, 0, 0); issue(0, 1, 4'b0001); idle();
    chk(resp_data[0] == fdat(0, 0), "R7", resp_data[0], fdat(0, 0));

    // Random conflict-free traffic, compared against the model every clock.
    cur_tag = "R4";
    for (int n = 0; n < 400; n++) begin
      logic [LANES-1:0] en;
      bit wr;
      wr = ($urandom_range(0, 2) == 0);
      en = LANES'($urandom);
      for (int l = 0; l < LANES; l++) begin
        lane_set(l, $urandom_range(0, BANKS-1), $urandom_range(0, DEPTH-1), $urandom, 4'($urandom));
        for (int k = 0; k < l; k++)
          if (en[k] && lane_bank[k] == lane_bank[l]) begin
            if (wr) en[l] = 0; else lane_off[l] = lane_off[k];
          end
      end
      if ($urandom_range(0, 4) == 0) idle();
      else issue(wr, $urandom_range(0, 1) == 1, en);
    end
    repeat (3) idle();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule